// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire MDIO/MDC management bus used to configure Ethernet PHYs. Software selects the frame format (Clause 22 or Clause 45), the MDC divisor and the output edge in a configuration register. It then starts frames by writing a small set of registers. The block serializes the whole frame: preamble, start code, opcode, port and device fields, turnaround and 16-bit payload. For reads it releases the line during turnaround and shifts in the PHY's answer.

The bidirectional data line is brought out as a driven value, an output enable and a sampled input; the pad and pull-up sit outside the block. MDC runs only while a frame is in flight. Busy flags let software poll for completion. A read the PHY did not acknowledge is flagged, and its result reads back as all ones.

Top module: `mdio_master`

## Requirements
- R1: Register index 0 (CFG) holds the format bit at bit 0 (0 = Clause 22, 1 = Clause 45), the edge-select bit at bit 1 and the MDC divisor at bits [8+DIV_W-1:8]. Bit 30 reads the read-error flag and bit 31 reads the bus-busy flag. Index 1 (CTRL) holds the port address at [4:0] and the device/register field at [12:8], with bit 16 as the read trigger. Index 2 (ADDR) and index 3 (DATA) take a 16-bit value in [15:0].
- R2: A Clause 22 frame is 32 ones, then start 01, then opcode 01 (write) or 10 (read). The 5-bit port address and the 5-bit CTRL[12:8] register number follow, then turnaround 10 on writes, then 16 data bits MSB first.
- R3: A Clause 45 frame has the same layout with start 00 and opcode 00 for address, 01 for write and 11 for read.
- R4: Writing DATA starts a write frame. Writing CTRL with bit 16 set starts a read frame using the fields written. Writing ADDR starts an address frame only in Clause 45 mode; in Clause 22 mode it starts nothing.
- R5: CFG bit 31 is high for the whole of every frame. DATA bit 31 is high only during read and write frames, never during address frames.
- R6: During a read the master releases MDIO from the first turnaround bit to frame end. It samples 16 bits on MDC rising edges, MSB first, and DATA[15:0] returns them.
- R7: If MDIO is high at the second turnaround bit of a read, CFG bit 30 is set and DATA[15:0] reads 0xFFFF. The flag clears when the next frame starts.
- R8: While a frame runs, MDC has a period of 2×divisor system clocks. MDC is low when idle. A divisor of 0 keeps MDC low and the frame does not advance.
- R9: With the edge-select bit set, MDIO output changes only at MDC falling edges. With it clear, MDIO changes one system clock after an MDC rising edge.
- R10: Register writes made while CFG bit 31 is high are ignored.
- R11: Outside a frame the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO driven value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO sampled value |

## Verification
The assertions check, on every cycle, the properties that relate signals directly:
- MDC stays low when idle and when the divisor is zero.
- The line is released when idle.
- Data-busy never appears without bus-busy.
- Output changes land on MDC falling edges in falling-edge mode.
- An error flag pairs with an all-ones result.
- Writes during a frame leave the control fields unchanged.

Only the bench scenarios show the rest. These are the bit-exact frame contents in both formats, the PHY's answer arriving in the data register, and the turnaround error. They also cover the address write that does nothing in Clause 22 mode and the MDC period for different divisors.

// File: rtl/mdio_pkg.sv
// Shared constants, frame kinds and frame assembly for the MDIO master.
// Assumes the standard 64-bit management frame with a full 32-bit preamble.
package mdio_pkg;

    localparam int FRAME_LEN = 64;
    localparam int TA_POS    = 46;   // first turnaround bit position
    localparam int DATA_POS  = 48;   // first payload bit position

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    typedef enum logic [1:0] {
        K_ADDR  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2
    } kind_e;

    // Builds the serial image of one frame, bit 63 transmitted first.
    function automatic logic [63:0] make_frame(input logic c45, input kind_e k,
                                               input logic [4:0] phy,
                                               input logic [4:0] dev,
                                               input logic [15:0] pay);
        logic [1:0] st;
        logic [1:0] op;
        st = c45 ? 2'b00 : 2'b01;
        case (k)
            K_ADDR:  op = 2'b00;
            K_WRITE: op = 2'b01;
            default: op = c45 ? 2'b11 : 2'b10;
        endcase
        return {32'hFFFF_FFFF, st, op, phy, dev, 2'b10, pay};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: divides the system clock by 2*div while run is high.
// Emits one-cycle pulses in the cycle whose edge raises or lowers MDC.
// Assumes div is held constant while run is high.
module mdio_clkgen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Half-period terminal count reached.
    assign wrap     = run && (div != '0) && (cnt == div - 1'b1);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    // Half-period counter and MDC toggle; parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (div != '0) begin
            if (wrap) begin
                cnt <= '0;
                mdc <= ~mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
// Frame engine: shifts a 64-bit frame onto MDIO, releases the line for the
// turnaround and data of reads, samples read data and the turnaround
// acknowledge on MDC rising edges. Assumes launch only arrives when idle.
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  kind_e       launch_kind,
    input  logic [63:0] launch_frame,
    input  logic        neg,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        active,
    output logic        data_busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_err,
    output logic [15:0] rd_data
);
    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN);
    localparam logic [CW-1:0] TA_P = CW'(TA_POS);
    localparam logic [CW-1:0] TA_2 = CW'(TA_POS + 1);
    localparam logic [CW-1:0] DT_P = CW'(DATA_POS);

    kind_e         kind;
    logic [63:0]   frame;
    logic [CW-1:0] done;    // MDC rising edges seen in this frame
    logic [CW-1:0] pos;     // bit currently presented
    logic          rise_d;
    logic [15:0]   shin;
    logic          adv;
    logic          is_read;
    logic [5:0]    bit_idx;

    assign is_read   = (kind == K_READ);
    assign adv       = neg ? fall_evt : rise_d;
    assign bit_idx   = ~pos[5:0];
    assign data_busy = active && (kind != K_ADDR);
    assign mdio_o    = (active && !pos[CW-1]) ? frame[bit_idx] : 1'b1;
    assign mdio_oe   = active && !pos[CW-1] && !(is_read && pos >= TA_P);

    // Frame sequencing, read sampling and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            kind    <= K_WRITE;
            frame   <= '0;
            done    <= '0;
            pos     <= '0;
            rise_d  <= 1'b0;
            shin    <= '0;
            rd_err  <= 1'b0;
            rd_data <= '0;
        end else if (!active) begin
            rise_d <= 1'b0;
            if (launch) begin
                active <= 1'b1;
                kind   <= launch_kind;
                frame  <= launch_frame;
                done   <= '0;
                pos    <= '0;
                rd_err <= 1'b0;
            end
        end else begin
            rise_d <= rise_evt;
            if (rise_evt) begin
                done <= done + 1'b1;
                if (is_read && done == TA_2)
                    rd_err <= mdio_i;
                if (is_read && done >= DT_P)
                    shin <= {shin[14:0], mdio_i};
            end
            if (adv)
                pos <= done;
            if (fall_evt && done == LAST) begin
                active <= 1'b0;
                if (is_read)
                    rd_data <= rd_err ? 16'hFFFF : shin;
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Register file: configuration, control fields, frame launch decode and read
// mux. All writes are dropped while a frame is in flight. Assumes DIV_W <= 21.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic             data_busy,
    input  logic             rd_err,
    input  logic [15:0]      rd_data,
    output logic             c45,
    output logic             neg,
    output logic [DIV_W-1:0] div,
    output logic [4:0]       ctrl_phy,
    output logic [4:0]       ctrl_dev,
    output logic             launch,
    output kind_e            launch_kind,
    output logic [63:0]      launch_frame
);
    logic       wr_ok;
    logic [4:0] phy_l;
    logic [4:0] dev_l;
    logic       unused_bits;

    assign wr_ok       = we && !busy;
    assign unused_bits = ^{wdata[31:17], wdata[15:13], wdata[7:5]};

    // Configuration and control field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45      <= 1'b0;
            neg      <= 1'b0;
            div      <= '0;
            ctrl_phy <= '0;
            ctrl_dev <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_CFG: begin
                    c45 <= wdata[0];
                    neg <= wdata[1];
                    div <= wdata[8 +: DIV_W];
                end
                SEL_CTRL: begin
                    ctrl_phy <= wdata[4:0];
                    ctrl_dev <= wdata[12:8];
                end
                default: ;
            endcase
        end
    end

    // Launch decode: which write starts which frame.
    always_comb begin
        launch      = 1'b0;
        launch_kind = K_WRITE;
        phy_l       = ctrl_phy;
        dev_l       = ctrl_dev;
        if (wr_ok) begin
            case (sel)
                SEL_CTRL: if (wdata[16]) begin
                    launch      = 1'b1;
                    launch_kind = K_READ;
                    phy_l       = wdata[4:0];
                    dev_l       = wdata[12:8];
                end
                SEL_ADDR: if (c45) begin
                    launch      = 1'b1;
                    launch_kind = K_ADDR;
                end
                SEL_DATA: launch = 1'b1;
                default: ;
            endcase
        end
        launch_frame = make_frame(c45, launch_kind, phy_l, dev_l, wdata[15:0]);
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CFG: begin
                rdata[0]          = c45;
                rdata[1]          = neg;
                rdata[8 +: DIV_W] = div;
                rdata[30]         = rd_err;
                rdata[31]         = busy;
            end
            SEL_CTRL: begin
                rdata[4:0]  = ctrl_phy;
                rdata[12:8] = ctrl_dev;
            end
            SEL_DATA: begin
                rdata[15:0] = rd_data;
                rdata[31]   = data_busy;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top: register file, MDC generator and frame engine.
// Assumes an external pad combines mdio_o/mdio_oe with a pull-up into mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             busy;
    logic             data_busy;
    logic             rd_err;
    logic [15:0]      rd_data;
    logic             c45;
    logic             neg;
    logic [DIV_W-1:0] div;
    logic [4:0]       ctrl_phy;
    logic [4:0]       ctrl_dev;
    logic             launch;
    kind_e            launch_kind;
    logic [63:0]      launch_frame;
    logic             rise_evt;
    logic             fall_evt;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .data_busy(data_busy), .rd_err(rd_err), .rd_data(rd_data),
        .c45(c45), .neg(neg), .div(div), .ctrl_phy(ctrl_phy),
        .ctrl_dev(ctrl_dev), .launch(launch), .launch_kind(launch_kind),
        .launch_frame(launch_frame)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
        .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .launch_kind(launch_kind), .launch_frame(launch_frame),
        .neg(neg), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .mdio_i(mdio_i), .active(busy), .data_busy(data_busy),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Protocol checker for mdio_master, attached by bind.
module mdio_master_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             data_busy,
    input logic             mdc,
    input logic             mdo,
    input logic             oe,
    input logic             neg,
    input logic             rd_err,
    input logic [15:0]      rd_data,
    input logic [DIV_W-1:0] div,
    input logic             reg_we,
    input logic [4:0]       ctrl_phy
);
    p_idle_mdc_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div == '0) |-> !mdc);
    p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !oe);
    p_neg_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && neg && !$stable(mdo)) |-> $fell(mdc));
    p_data_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_busy |-> busy);
    p_err_ffff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !busy) |-> (rd_data == 16'hFFFF));
    p_busy_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> (ctrl_phy == $past(ctrl_phy)));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .data_busy(data_busy),
    .mdc(mdc), .mdo(mdio_o), .oe(mdio_oe), .neg(neg), .rd_err(rd_err),
    .rd_data(rd_data), .div(div), .reg_we(reg_we), .ctrl_phy(ctrl_phy)
);

// File: tb/mdio_master_tb.sv
// Scoreboard bench: tasks queue expected frame images; a PHY model captures
// frames from the wire at MDC rising edges and compares them in order.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] exp_q[$];
    logic        phy_ack = 1'b1;
    logic [15:0] phy_resp = '0;
    logic        phy_out = 1'b1;
    int          cur_div = 2;
    logic        cur_neg = 1'b1;

    assign mdio_i = mdio_oe ? mdio_o : phy_out;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] p, input logic [4:0] d,
                                       input logic [1:0] ta, input logic [15:0] v);
        return {32'hFFFF_FFFF, st, op, p, d, ta, v};
    endfunction

    // PHY model and monitor, sampled away from the active edge.
    int          cap_cnt = 0;
    logic [63:0] cap = '0;
    logic        mdc_q = 1'b0, oe_q = 1'b0, mdo_q = 1'b1;
    int          cyc = 0, last_rise = 0;
    int          per_bad = 0, edge_bad = 0, frames_seen = 0, mdc_high = 0;
    always @(negedge clk) begin
        logic bitv;
        logic [63:0] e;
        cyc++;
        if (mdc) mdc_high++;
        if (mdio_oe && oe_q && mdio_o != mdo_q) begin
            if (cur_neg ? !(!mdc && mdc_q) : !(mdc && mdc_q)) edge_bad++;
        end
        if (mdio_oe && !oe_q) cap_cnt = 0;
        if (mdc && !mdc_q) begin
            if (cap_cnt > 0 && (cyc - last_rise) != 2 * cur_div) per_bad++;
            last_rise = cyc;
            bitv = mdio_oe ? mdio_o : phy_out;
            cap = {cap[62:0], bitv};
            cap_cnt++;
            if (cap_cnt == 46) phy_out <= 1'b1;
            else if (cap_cnt == 47) phy_out <= !phy_ack;
            else if (cap_cnt >= 48 && cap_cnt <= 63) phy_out <= phy_resp[63 - cap_cnt];
            else phy_out <= 1'b1;
            if (cap_cnt == 64) begin
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected frame", cap, '0);
                end else begin
                    e = exp_q.pop_front();
                    check(cap == e, "R2/R3", "frame image", cap, e);
                end
            end
        end
        mdc_q = mdc;
        oe_q  = mdio_oe;
        mdo_q = mdio_o;
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic set_cfg(input logic c45, input logic ng, input int dv);
        cur_div = dv; cur_neg = ng;
        wr(2'd0, (32'(dv) << 8) | (32'(ng) << 1) | 32'(c45));
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int k = 0;
        do begin rd(2'd0, v); k++; end while (v[31] && k < 20000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state.
        rd(2'd0, v);
        check(v == 32'd0, "R1", "CFG after reset", v, 0);
        check(!mdc && !mdio_oe, "R11", "idle pins", {mdc, mdio_oe}, 0);

        // R8: divisor zero keeps MDC low and the frame stalls.
        wr(2'd3, 32'h0000_A5A5);
        mdc_high = 0;
        repeat (100) @(negedge clk);
        check(mdc_high == 0, "R8", "MDC high cycles with div 0", mdc_high, 0);
        rd(2'd0, v);
        check(v[31] == 1'b1, "R8", "stalled frame busy", v[31], 1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(2'd0, v);
        check(v[31] == 1'b0 && !mdio_oe, "R11", "idle after reset", v, 0);

        // R2: Clause 22 write, falling-edge mode.
        set_cfg(1'b0, 1'b1, 2);
        wr(2'd1, {19'd0, 5'd5, 3'd0, 5'd3});
        exp_q.push_back(fr(2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'hBEEF));
        wr(2'd3, 32'h0000_BEEF);
        repeat (10) @(negedge clk);
        rd(2'd0, v);
        check(v[31] == 1'b1, "R5", "bus busy during write", v[31], 1);
        rd(2'd3, v);
        check(v[31] == 1'b1, "R5", "data busy during write", v[31], 1);
        wait_idle();
        check(!mdio_oe, "R11", "released after write", mdio_oe, 0);

        // R6: Clause 22 read with acknowledge.
        phy_ack = 1'b1; phy_resp = 16'h1234;
        exp_q.push_back(fr(2'b01, 2'b10, 5'd3, 5'd5, 2'b10, 16'h1234));
        wr(2'd1, {15'd0, 1'b1, 3'd0, 5'd5, 3'd0, 5'd3});
        wait_idle();
        rd(2'd3, v);
        check(v[15:0] == 16'h1234, "R6", "C22 read data", v[15:0], 16'h1234);
        rd(2'd0, v);
        check(v[30] == 1'b0, "R7", "no error on ack", v[30], 0);

        // R7: no acknowledge at the second turnaround bit.
        phy_ack = 1'b0; phy_resp = 16'h5A5A;
        exp_q.push_back(fr(2'b01, 2'b10, 5'd4, 5'd1, 2'b11, 16'h5A5A));
        wr(2'd1, {15'd0, 1'b1, 3'd0, 5'd1, 3'd0, 5'd4});
        wait_idle();
        rd(2'd0, v);
        check(v[30] == 1'b1, "R7", "error flag", v[30], 1);
        rd(2'd3, v);
        check(v[15:0] == 16'hFFFF, "R7", "error data", v[15:0], 16'hFFFF);
        phy_ack = 1'b1;

        // R4: ADDR write in Clause 22 mode starts nothing.
        f0 = frames_seen;
        wr(2'd2, 32'h0000_0077);
        repeat (30) @(negedge clk);
        rd(2'd0, v);
        check(v[31] == 1'b0 && frames_seen == f0, "R4", "C22 ADDR ignored", v[31], 0);

        // R3: Clause 45 address, write and read.
        set_cfg(1'b1, 1'b1, 2);
        wr(2'd1, {19'd0, 5'd7, 3'd0, 5'd1});
        exp_q.push_back(fr(2'b00, 2'b00, 5'd1, 5'd7, 2'b10, 16'h1234));
        wr(2'd2, 32'h0000_1234);
        repeat (10) @(negedge clk);
        rd(2'd3, v);
        check(v[31] == 1'b0, "R5", "no data busy on address frame", v[31], 0);
        rd(2'd0, v);
        check(v[31] == 1'b1 && v[30] == 1'b0, "R7", "busy, error cleared", v[31:30], 2'b10);
        wait_idle();
        exp_q.push_back(fr(2'b00, 2'b01, 5'd1, 5'd7, 2'b10, 16'hCAFE));
        wr(2'd3, 32'h0000_CAFE);
        wait_idle();
        phy_resp = 16'h0F0F;
        exp_q.push_back(fr(2'b00, 2'b11, 5'd1, 5'd7, 2'b10, 16'h0F0F));
        wr(2'd1, {15'd0, 1'b1, 3'd0, 5'd7, 3'd0, 5'd1});
        wait_idle();
        rd(2'd3, v);
        check(v[15:0] == 16'h0F0F, "R6", "C45 read data", v[15:0], 16'h0F0F);

        // R10: writes while busy are dropped.
        f0 = frames_seen;
        exp_q.push_back(fr(2'b00, 2'b01, 5'd1, 5'd7, 2'b10, 16'h1111));
        wr(2'd3, 32'h0000_1111);
        repeat (30) @(negedge clk);
        wr(2'd3, 32'h0000_2222);
        wr(2'd1, {19'd0, 5'd7, 3'd0, 5'd9});
        wait_idle();
        repeat (300) @(negedge clk);
        rd(2'd1, v);
        check(v[4:0] == 5'd1, "R10", "CTRL unchanged", v[4:0], 1);
        check(frames_seen == f0 + 1, "R10", "frames after busy writes", frames_seen, f0 + 1);

        // R9/R8: rising-edge mode with divisor 3.
        set_cfg(1'b0, 1'b0, 3);
        exp_q.push_back(fr(2'b01, 2'b01, 5'd2, 5'd6, 2'b10, 16'h8001));
        wr(2'd1, {19'd0, 5'd6, 3'd0, 5'd2});
        wr(2'd3, 32'h0000_8001);
        wait_idle();
        repeat (5) @(negedge clk);
        check(per_bad == 0, "R8", "MDC period mismatches", per_bad, 0);
        check(edge_bad == 0, "R9", "MDIO change edge violations", edge_bad, 0);
        check(exp_q.size() == 0, "R4", "frames still expected", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule